// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Bus Master)

This block drives a three-wire stereo audio link as the clock master. It makes the bit clock and the word-select line itself, using a programmable prescaler. When the converter at the far end needs a faster reference clock, the block can also make one. Software writes 16-bit samples one at a time into a single holding register. At the start of each channel slot, the block copies that register into a 16-bit shift register. It then sends the sample on the data line with the most significant bit first, and the slots alternate left and right.

A status flag tells software when the holding register is free again. Software can enable an interrupt on that flag. A channel flag tells software whether the next write belongs to the right channel. A busy flag shows that the link is running. The first sample written after enabling is always a left sample, and every frame is one left slot followed by one right slot. If a slot begins while the holding register is still empty, the block sends zeros for that slot and pulses an underrun output. Left/right alignment is kept.

When the enable is removed, the link keeps running until the holding register is empty and a frame boundary is reached. It then parks all lines at their idle levels.

Top module: `i2s_tx_master`

## Requirements
- R1: After reset: `busy`=0, `buf_empty`=1, `chan_right`=0, `underrun`=0, `ws`=0, `sd`=0, `mck`=0, and `ck` equals `cfg_cpol`.
- R2: With `cfg_mck_en`=0, each half period of `ck` lasts H = 2*max(`cfg_div`,1) + `cfg_odd` clock cycles.
- R3: With `cfg_mck_en`=1, each half period of `mck` lasts H cycles and each half period of `ck` lasts 8*H cycles. `mck` is held at 0 whenever `en` is low and the link is idle.
- R4: The idle level of `ck` equals `cfg_cpol`. `sd` and `ws` change only on the edge where `ck` returns to its idle level. The receiver samples on the opposite edge.
- R5: The link starts only when `en`=1 and the holding register is full. The first word sent is left. A frame is 32 bit slots, and `ws` is low for slots 0..15 and high for slots 16..31. `ws` therefore changes one bit before each channel's MSB.
- R6: Each sample is sent MSB first. A left word occupies slots 1..16. A right word occupies slots 17..31 and slot 0 of the following frame.
- R7: `buf_empty` rises when the holding register moves into the shift register. A write while `buf_empty`=0 is ignored.
- R8: `chan_right` changes only when a slot is loaded. It reads 1 after a left load and 0 after a right load, so it names the channel of the next write.
- R9: `irq` is high exactly when `cfg_irq_en`=1 and `buf_empty`=1.
- R10: If a slot starts with the holding register empty, the slot carries all zeros, `underrun` pulses for one cycle, and channel order is preserved.
- R11: After `en` falls, the link stops only at a frame boundary with the holding register empty, so no half frame is ever sent. At that point `busy` goes low and `ck`, `ws` and `sd` park at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Link enable |
| cfg_div | input | 8 | Linear prescaler value |
| cfg_odd | input | 1 | Adds one cycle to the prescaler half period |
| cfg_cpol | input | 1 | Idle level of the bit clock |
| cfg_mck_en | input | 1 | Enable the reference clock output |
| cfg_irq_en | input | 1 | Enable the empty interrupt |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Sample to write |
| ck | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| mck | output | 1 | Reference clock for the converter |
| buf_empty | output | 1 | Holding register free |
| chan_right | output | 1 | Next write belongs to the right channel |
| busy | output | 1 | Link running |
| underrun | output | 1 | One-cycle pulse when a slot starts with no sample |
| irq | output | 1 | Empty interrupt |

## Verification
The hardest case to reach is a shutdown requested in the middle of a frame that still owes a slot. The bench reaches it in two ways. First, it writes a right sample and drops the enable in the same cycle. Second, it writes only a left sample and drops the enable, which forces a zero-filled right slot and an underrun before the link may stop. A decoder in the bench rebuilds every word from the bit clock and word select. It therefore catches a lost slot, a truncated frame or a misaligned channel.

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int DW       = 16,
  parameter int PW       = 8,
  parameter int MCK_HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] cfg_div,
  input  logic          cfg_odd,
  input  logic          cfg_cpol,
  input  logic          cfg_mck_en,
  input  logic          cfg_irq_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          ck,
  output logic          ws,
  output logic          sd,
  output logic          mck,
  output logic          buf_empty,
  output logic          chan_right,
  output logic          busy,
  output logic          underrun,
  output logic          irq
);
  localparam int HW   = PW + 1;
  localparam int BCW  = $clog2(2 * DW);
  localparam int SUBW = $clog2(MCK_HALF);

  logic            running, ck_ph, buf_full, chan_q, ws_q, mck_q, urun_q;
  logic [HW-1:0]   pcnt;
  logic [SUBW-1:0] sub;
  logic [BCW-1:0]  bitc;
  logic [DW-1:0]   shreg, buf_q;

  wire [HW-1:0]  half    = {(cfg_div == '0) ? PW'(1) : cfg_div, cfg_odd};
  wire           pre_on  = en | running;
  wire           tick    = pre_on && (pcnt == half - HW'(1));
  wire           ck_evt  = running && tick && (!cfg_mck_en || sub == SUBW'(MCK_HALF - 1));
  wire           drive   = ck_evt && ck_ph;
  wire           start   = en && buf_full && !running;
  wire [BCW-1:0] nxt     = (bitc == BCW'(2 * DW - 1)) ? '0 : bitc + BCW'(1);
  wire           bound   = (nxt == BCW'(1));
  wire           slot    = drive && (bound || nxt == BCW'(DW + 1));
  wire           stop    = drive && bound && !en && !buf_full;
  wire           load    = slot && !stop;
  wire           wr_ok   = wr_valid && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; sub <= '0; mck_q <= 1'b0; running <= 1'b0; ck_ph <= 1'b0;
      bitc <= '0; ws_q <= 1'b0; shreg <= '0; buf_q <= '0; buf_full <= 1'b0;
      chan_q <= 1'b0; urun_q <= 1'b0;
    end else begin
      if (start || !pre_on || tick) pcnt <= '0;
      else                          pcnt <= pcnt + HW'(1);

      if (start || !running || !cfg_mck_en) sub <= '0;
      else if (tick)
        sub <= (sub == SUBW'(MCK_HALF - 1)) ? '0 : sub + SUBW'(1);

      if (!pre_on || !cfg_mck_en || start) mck_q <= 1'b0;
      else if (tick)                       mck_q <= ~mck_q;

      if (start)     running <= 1'b1;
      else if (stop) running <= 1'b0;

      if (start || stop) ck_ph <= 1'b0;
      else if (ck_evt)   ck_ph <= ~ck_ph;

      if (start || stop) begin
        bitc  <= '0;
        ws_q  <= 1'b0;
        shreg <= '0;
      end else if (drive) begin
        bitc  <= nxt;
        ws_q  <= (nxt >= BCW'(DW));
        shreg <= load ? (buf_full ? buf_q : '0) : (shreg << 1);
      end

      if (wr_ok) begin
        buf_q    <= wr_data;
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end

      if (load) chan_q <= bound;
      urun_q <= load && !buf_full;
    end
  end

  assign ck         = ck_ph ^ cfg_cpol;
  assign ws         = ws_q;
  assign sd         = shreg[DW-1];
  assign mck        = mck_q;
  assign buf_empty  = !buf_full;
  assign chan_right = chan_q;
  assign busy       = running;
  assign underrun   = urun_q;
  assign irq        = cfg_irq_en & !buf_full;

  assert_ws_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> (ck == cfg_cpol && $past(ck) != cfg_cpol));
  assert_sd_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> (ck == cfg_cpol && $past(ck) != cfg_cpol));
  assert_empty_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> ($past(busy) && ck == cfg_cpol));
  assert_chan_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_right) |-> ($rose(buf_empty) || underrun));
  assert_underrun_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (buf_empty && !sd && busy));
  assert_idle_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ck == cfg_cpol && !ws && !sd));
  assert_stop_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(buf_empty) && !$past(en) && !$past(ws)));
endmodule

// File: tb/i2s_tx_master_tb_top.sv
module i2s_tx_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, cfg_odd = 1'b0, cfg_cpol = 1'b0, cfg_mck_en = 1'b0, cfg_irq_en = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic ck, ws, sd, mck, buf_empty, chan_right, busy, underrun, irq;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [15:0] words [0:63];
  logic        chans [0:63];
  int nwords = 0, nurun = 0, ck_int = 0, mck_int = 0;
  int ck_t = 0, mck_t = 0, cnt = -1;
  logic ck_last = 1'b0, mck_last = 1'b0, wsp = 1'b0;
  logic [15:0] acc = '0;

  i2s_tx_master dut_i (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!busy) begin cnt = -1; wsp = 1'b0; end
    if (underrun) nurun = nurun + 1;
    if (mck !== mck_last) begin mck_int = cyc - mck_t; mck_t = cyc; end
    mck_last = mck;
    if (ck !== ck_last) begin
      ck_int = cyc - ck_t; ck_t = cyc;
      if (busy && ck != cfg_cpol) begin
        if (ws != wsp) begin
          if (cnt == 15 && nwords < 64) begin
            words[nwords] = {acc[14:0], sd}; chans[nwords] = wsp; nwords = nwords + 1;
          end
          cnt = 0;
        end else if (cnt < 0) cnt = 0;
        else begin acc = {acc[14:0], sd}; cnt = cnt + 1; end
        wsp = ws;
      end
    end
    ck_last = ck;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 20000 && !buf_empty; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 buf_empty", buf_empty, 1);
    chk("R1 chan_right", chan_right, 0); chk("R1 underrun", underrun, 0);
    chk("R1 ws", ws, 0); chk("R1 sd", sd, 0); chk("R1 mck", mck, 0);
    chk("R1 ck", ck, cfg_cpol);
  endtask

  task automatic t_stream();
    logic [15:0] v [4] = '{16'hA5C3, 16'h1234, 16'h8001, 16'h7FFE};
    int base = nwords;
    cfg_div = 8'd1; cfg_odd = 1'b0; cfg_cpol = 1'b0; cfg_mck_en = 1'b0;
    en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_empty();
      chk("R8 chan before write", chan_right, i % 2);
      wr(v[i]);
      chk("R7 full after write", buf_empty, 0);
    end
    en = 1'b0;
    @(negedge clk);
    chk("R11 busy held after disable", busy, 1);
    wait_idle();
    chk("R5 word count", nwords - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 word value", words[base + i], v[i]);
      chk("R5 word channel", chans[base + i], i % 2);
    end
    chk("R11 ck idle", ck, 0);
  endtask

  task automatic t_period();
    cfg_div = 8'd2; cfg_odd = 1'b1; cfg_mck_en = 1'b0;
    en = 1'b1; wr(16'h0F0F); wait_empty(); wr(16'hF0F0); en = 1'b0;
    repeat (60) @(negedge clk);
    chk("R2 ck half period", ck_int, 5);
    wait_idle();
    cfg_div = 8'd1; cfg_odd = 1'b0; cfg_mck_en = 1'b1;
    en = 1'b1; wr(16'h3C3C); wait_empty(); wr(16'hC3C3); en = 1'b0;
    repeat (300) @(negedge clk);
    chk("R3 mck half period", mck_int, 2);
    chk("R3 ck half period", ck_int, 16);
    wait_idle();
    chk("R3 mck parked", mck, 0);
    cfg_mck_en = 1'b0;
  endtask

  task automatic t_cpol();
    int base = nwords;
    cfg_cpol = 1'b1;
    @(negedge clk);
    chk("R4 idle high", ck, 1);
    en = 1'b1; wr(16'hF00F); wait_empty(); wr(16'h0FF0); en = 1'b0;
    wait_idle();
    chk("R4 words", nwords - base, 2);
    chk("R4 left", words[base], 16'hF00F);
    chk("R4 right", words[base + 1], 16'h0FF0);
    chk("R4 parked high", ck, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_full();
    int base = nwords;
    wr(16'hAAAA);
    chk("R5 no start without en", busy, 0);
    wr(16'hBBBB);
    en = 1'b1;
    wait_empty();
    chk("R8 right next", chan_right, 1);
    wr(16'hCCCC); en = 1'b0;
    wait_idle();
    chk("R7 word count", nwords - base, 2);
    chk("R7 ignored write", words[base], 16'hAAAA);
    chk("R7 right word", words[base + 1], 16'hCCCC);
  endtask

  task automatic t_underrun();
    int base = nwords, ub = nurun;
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq when empty", irq, 1);
    wr(16'h9669);
    chk("R9 irq low when full", irq, 0);
    en = 1'b1;
    wait_empty();
    en = 1'b0;
    wait_idle();
    chk("R10 underrun pulses", nurun - ub, 1);
    chk("R10 word count", nwords - base, 2);
    chk("R10 left kept", words[base], 16'h9669);
    chk("R10 zero right", words[base + 1], 0);
    chk("R10 right channel", chans[base + 1], 1);
    chk("R8 chan after frame", chan_right, 0);
    chk("R9 irq at end", irq, 1);
    cfg_irq_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_stream();
    t_period();
    t_cpol();
    t_full();
    t_underrun();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule